// File: doc/BRIEF.md
# Event-Triggered Delayed Pulse Generator

This block watches a stream of received event codes, one per event-clock cycle, and answers a single programmed code with one output pulse. After a programmable number of event-clock cycles the pulse goes active and stays active for a programmed whole number of event clocks. It then returns to its inactive level. The output polarity is selectable, and an external inhibit input both blocks new triggers and cuts off a pulse that is already running.

Timing finer than one event clock is not produced here. At the moment a trigger is accepted, the block captures a 2-bit phase-step select and a 10-bit fine-delay code and holds them on its outputs. An external phase shifter uses the select to add 0, 2, 4 or 6 ns, one 2 ns step per count. A 1024-step delay line uses the fine code at roughly 10 ps per step. The total delay is the coarse count in event clocks plus the phase step plus the fine step.

Top module: `evt_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released with no trigger, `pulse_out` sits at its inactive level, which equals `cfg_invert`, and `phase_sel` and `fine_code` are zero.
- R2: A trigger is accepted at a clock edge only if `evt_valid` is 1 and `evt_code` equals `cfg_code`. A code that does not match, or a matching code with `evt_valid` at 0, produces no pulse.
- R3: Let the accepting edge be edge 0. The pulse becomes active right after edge `cfg_coarse`. With a coarse value of 0 it becomes active right after the accepting edge.
- R4: Once active, the pulse stays active for exactly `cfg_width` event-clock cycles, provided inhibit stays low.
- R5: If `cfg_width` is 0, a matching event is not accepted and no pulse appears.
- R6: `phase_sel` and `fine_code` take the values of `cfg_phase` and `cfg_fine` at the accepting edge. They hold those values until the next accepted trigger, and configuration changes at any other time do not reach them.
- R7: When `cfg_invert` is 1, the pulse is active-low: the output idles at 1 and drops to 0 while active. When it is 0, the pulse is active-high.
- R8: If `inhibit` rises while the pulse is active, `pulse_out` goes to its inactive level in that same cycle, with no register in the path. The pulse is then terminated and does not resume when `inhibit` falls.
- R9: A matching event that arrives while `inhibit` is 1 is ignored.
- R10: A matching event that arrives while a delay or a pulse is in progress is ignored. It changes neither the timing of the running pulse nor `phase_sel` or `fine_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_code | input | 8 | Received event code |
| evt_valid | input | 1 | Qualifies `evt_code` in this cycle |
| cfg_code | input | 8 | Event code that fires the trigger |
| cfg_coarse | input | 16 | Delay in event-clock cycles |
| cfg_phase | input | 2 | Phase-step select, in 2 ns steps |
| cfg_fine | input | 10 | Fine delay-line code |
| cfg_width | input | 32 | Pulse width in event-clock cycles |
| cfg_invert | input | 1 | 1 selects an active-low output |
| inhibit | input | 1 | External inhibit |
| pulse_out | output | 1 | Trigger pulse |
| phase_sel | output | 2 | Captured phase-step select |
| fine_code | output | 10 | Captured fine-delay code |

## Verification
The leading edge of the pulse is due `cfg_coarse` cycles after the accepting edge, and the trailing edge is due `cfg_width` cycles after the leading edge. The captured phase and fine codes appear one edge after acceptance. The inhibit gate acts within the same cycle. The bench keeps a behavioural countdown model that is updated on each rising edge from the inputs it drove at the previous falling edge. One time unit after driving the new inputs, it compares all three outputs against the model on every cycle, so each of these latencies is checked in exactly the cycle where it falls due.

// File: rtl/epg_pkg.sv
package epg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_ACTIVE = 2'd2
    } epg_state_e;
endpackage

// File: rtl/epg_match.sv
module epg_match #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] evt_code,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              width_nz,
    input  logic              inhibit,
    input  logic              idle,
    output logic              accept
);
    // Trigger qualification: code match, valid, free, not inhibited, usable width
    always_comb begin
        accept = evt_valid && (evt_code == cfg_code) && idle && !inhibit && width_nz;
    end
endmodule

// File: rtl/epg_outstage.sv
module epg_outstage (
    input  logic active,
    input  logic inhibit,
    input  logic invert,
    output logic pulse
);
    // Inhibit gates without a register so it takes effect in the same cycle
    always_comb begin
        pulse = (active && !inhibit) ^ invert;
    end
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen
    import epg_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int COARSE_W = 16,
    parameter int WIDTH_W  = 32,
    parameter int PHASE_W  = 2,
    parameter int FINE_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   evt_code,
    input  logic                evt_valid,
    input  logic [CODE_W-1:0]   cfg_code,
    input  logic [COARSE_W-1:0] cfg_coarse,
    input  logic [PHASE_W-1:0]  cfg_phase,
    input  logic [FINE_W-1:0]   cfg_fine,
    input  logic [WIDTH_W-1:0]  cfg_width,
    input  logic                cfg_invert,
    input  logic                inhibit,
    output logic                pulse_out,
    output logic [PHASE_W-1:0]  phase_sel,
    output logic [FINE_W-1:0]   fine_code
);
    localparam int CNT_W = (COARSE_W > WIDTH_W) ? COARSE_W : WIDTH_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        epg_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [PHASE_W-1:0]  phase;
        logic [FINE_W-1:0]   fine;
    } epg_regs_t;

    epg_regs_t r_d, r_q;
    logic      accept;
    logic      active;

    epg_match #(.CODE_W(CODE_W)) u_match (
        .evt_code (evt_code),
        .evt_valid(evt_valid),
        .cfg_code (cfg_code),
        .width_nz (|cfg_width),
        .inhibit  (inhibit),
        .idle     (r_q.st == ST_IDLE),
        .accept   (accept)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.phase = cfg_phase;
                    r_d.fine  = cfg_fine;
                    if (cfg_coarse == '0) begin
                        r_d.st  = ST_ACTIVE;
                        r_d.cnt = CNT_W'(cfg_width);
                    end else begin
                        r_d.st  = ST_DELAY;
                        r_d.cnt = CNT_W'(cfg_coarse);
                    end
                end
            end
            ST_DELAY: begin
                if (r_q.cnt == CNT_ONE) begin
                    r_d.st  = ST_ACTIVE;
                    r_d.cnt = CNT_W'(cfg_width);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            ST_ACTIVE: begin
                if (inhibit || r_q.cnt == CNT_ONE) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, phase: '0, fine: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign active    = (r_q.st == ST_ACTIVE);
    assign phase_sel = r_q.phase;
    assign fine_code = r_q.fine;

    epg_outstage u_out (
        .active (active),
        .inhibit(inhibit),
        .invert (cfg_invert),
        .pulse  (pulse_out)
    );

    // Captured codes never move while a delay or pulse is running
    assert_hold_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> ($stable(phase_sel) && $stable(fine_code)));

    // Inhibit during the pulse ends it at the next edge
    assert_inhibit_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && inhibit) |=> (r_q.st == ST_IDLE));

    // Output sits at the inactive level whenever inhibit is high
    assert_inhibit_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (pulse_out == cfg_invert));

    // Last delay count hands over to the active phase
    assert_delay_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DELAY && r_q.cnt == CNT_ONE) |=> active);

    // A pulse can only begin from an accepted trigger or an expiring delay
    assert_start_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(accept) || $past(r_q.st == ST_DELAY)));
endmodule

// File: tb/evt_pulse_gen_test.sv
module evt_pulse_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_code = '0;
    logic        evt_valid = 1'b0;
    logic [7:0]  cfg_code = 8'h44;
    logic [15:0] cfg_coarse = '0;
    logic [1:0]  cfg_phase = '0;
    logic [9:0]  cfg_fine = '0;
    logic [31:0] cfg_width = 32'd1;
    logic        cfg_invert = 1'b0;
    logic        inhibit = 1'b0;
    logic        pulse_out;
    logic [1:0]  phase_sel;
    logic [9:0]  fine_code;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural model state
    bit     m_busy = 0;
    longint m_wait = 0;
    longint m_left = 0;
    int     m_phase = 0;
    int     m_fine = 0;

    always #2 clk = ~clk;

    evt_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .evt_valid(evt_valid),
        .cfg_code(cfg_code), .cfg_coarse(cfg_coarse), .cfg_phase(cfg_phase),
        .cfg_fine(cfg_fine), .cfg_width(cfg_width), .cfg_invert(cfg_invert),
        .inhibit(inhibit), .pulse_out(pulse_out), .phase_sel(phase_sel),
        .fine_code(fine_code)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_wait = 0; m_left = 0; m_phase = 0; m_fine = 0;
        end else if (m_busy) begin
            if (m_wait > 0) m_wait = m_wait - 1;
            else if (inhibit) m_busy = 0;
            else begin
                m_left = m_left - 1;
                if (m_left == 0) m_busy = 0;
            end
        end else if (evt_valid && evt_code == cfg_code && !inhibit && cfg_width != 0) begin
            m_busy = 1; m_wait = cfg_coarse; m_left = cfg_width;
            m_phase = cfg_phase; m_fine = cfg_fine;
        end
    end

    task automatic check(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!done) begin
            check("pulse_out", pulse_out,
                  ((m_busy && m_wait == 0 && !inhibit) ? 1 : 0) ^ cfg_invert);
            check("phase_sel", phase_sel, m_phase);
            check("fine_code", fine_code, m_fine);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(logic [7:0] code, logic vld);
        @(negedge clk);
        evt_code = code; evt_valid = vld;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R2";
        cfg_coarse = 16'd3; cfg_width = 32'd4; cfg_phase = 2'd2; cfg_fine = 10'd100;
        send(8'h45, 1'b1);
        send(8'h44, 1'b0);
        idle(8);

        cur_req = "R3 R4";
        send(8'h44, 1'b1);
        idle(10);

        cur_req = "R3 coarse zero";
        cfg_coarse = 16'd0; cfg_width = 32'd1;
        send(8'h44, 1'b1);
        idle(4);

        cur_req = "R6";
        cfg_coarse = 16'd2; cfg_width = 32'd3; cfg_phase = 2'd3; cfg_fine = 10'd1023;
        send(8'h44, 1'b1);
        cfg_phase = 2'd1; cfg_fine = 10'd5;
        idle(8);

        cur_req = "R10";
        cfg_coarse = 16'd4; cfg_width = 32'd5; cfg_phase = 2'd0; cfg_fine = 10'd7;
        send(8'h44, 1'b1);
        cfg_phase = 2'd2; cfg_fine = 10'd600; cfg_coarse = 16'd1;
        send(8'h44, 1'b1);
        idle(3);
        send(8'h44, 1'b1);
        idle(8);

        cur_req = "R5";
        cfg_width = 32'd0; cfg_coarse = 16'd1; cfg_phase = 2'd1;
        send(8'h44, 1'b1);
        idle(6);

        cur_req = "R7";
        cfg_invert = 1'b1; cfg_width = 32'd3; cfg_coarse = 16'd2;
        idle(2);
        send(8'h44, 1'b1);
        idle(7);
        cfg_invert = 1'b0;

        cur_req = "R8";
        cfg_coarse = 16'd1; cfg_width = 32'd10;
        send(8'h44, 1'b1);
        idle(3);
        inhibit = 1'b1;
        idle(2);
        inhibit = 1'b0;
        idle(12);

        cur_req = "R9";
        @(negedge clk);
        inhibit = 1'b1; evt_code = 8'h44; evt_valid = 1'b1;
        @(negedge clk);
        inhibit = 1'b0; evt_valid = 1'b0;
        idle(14);

        cur_req = "R2 other code";
        cfg_code = 8'hA5; cfg_coarse = 16'd2; cfg_width = 32'd2;
        send(8'h44, 1'b1);
        idle(5);
        send(8'hA5, 1'b1);
        idle(6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule